// File: doc/BRIEF.md
# Sub-Second Masked Alarm Comparator

This block keeps the sub-second part of an alarm setting and compares it with the running sub-second counter of a time-keeping prescaler. A 4-bit mask selects how many of the counter's low-order bits must equal the stored match value. A mask of zero turns off the sub-second compare, and the seconds-increment strobe triggers the alarm instead. Logic outside this block compares the other alarm fields (seconds, minutes and so on) and reports the result on a single enable input. The alarm fires only while that enable is high.

When the trigger condition becomes true, the block raises a one-cycle event and sets a sticky flag. Software clears the flag by writing zero. The alarm setting register can be written only after a two-key unlock sequence. The write must also come while the alarm-write-allowed flag or initialization mode is active. The setting lives in the backup reset domain and keeps its value through a system reset.

Top module: `ssalarm_cmp`

## Requirements
- R1: A backup-domain reset clears the setting register to 0x0000_0000. A system reset clears the unlock state, the event output and the sticky flag, and leaves the setting register unchanged.
- R2: The setting reads back as mask in bits 27:24 and match value in bits 14:0. All other bits always read 0, even after a write of all ones.
- R3: `wr_sel` selects the target: 0 is the setting, 1 is the key, 2 is the flag. A key write of 0xCA (data bits 7:0) followed directly by a key write of 0x53 unlocks. Any other key write locks again, except that 0xCA restarts the sequence. Setting writes are ignored while locked.
- R4: An unlocked setting write takes effect only when `alm_wr_allow` or `init_mode` is 1. Otherwise it is ignored.
- R5: With mask 0, the trigger condition is `sec_tick` AND `fields_match`. The counter value plays no part.
- R6: With mask n in 1..14, the condition is `fields_match` AND counter bits [n-1:0] equal to match bits [n-1:0]. Bits [14:n] are ignored.
- R7: With mask 15, all 15 low counter bits must equal the match value.
- R8: Counter bit 15 never affects the compare.
- R9: No event occurs while `fields_match` is 0.
- R10: `alarm_pulse` is high for exactly one cycle, in the cycle after the clock edge at which the condition goes from false to true. A condition that stays true gives no further pulse.
- R11: `alarm_flag` is set together with each pulse. A flag write with data bit 0 = 0 clears it, and a write with bit 0 = 1 has no effect. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_bkp_n | input | 1 | Backup-domain reset, async active low |
| rst_sys_n | input | 1 | System reset, async active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 setting, 1 key, 2 flag |
| wr_data | input | 32 | Write data |
| alm_wr_allow | input | 1 | Alarm setting may be changed |
| init_mode | input | 1 | Initialization mode active |
| ss_cnt | input | 16 | Sub-second counter, bit 15 is overflow |
| sec_tick | input | 1 | Seconds-increment strobe |
| fields_match | input | 1 | Other alarm fields match |
| cfg_rdata | output | 32 | Setting register readback |
| wp_unlocked | output | 1 | Write protection open |
| alarm_pulse | output | 1 | One-cycle alarm event |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
A down-counting prescaler model drives the compare with full, partial (mask 1, 3, 14) and zero masks. Match values are chosen so that their high bits never occur in the count, which makes an unmasked high bit show up as a missing event. The same laps are repeated with the overflow bit set and with the field enable low, to separate the ignored bit from the gating input. A frozen counter sitting on the match value tells edge detection apart from level detection, and a flag clear landing on a trigger edge checks set priority. Setting writes are issued locked, unlocked without permission, after a bad key, and under each permission input, to separate the two gates.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_KEY  = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    WP_LOCKED = 2'd0,
    WP_HALF   = 2'd1,
    WP_OPEN   = 2'd2
  } wp_state_e;

  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hCA;
  localparam logic [KEY_W-1:0] KEY_SECOND = 8'h53;
endpackage

// File: rtl/ssa_rst_sync.sv
module ssa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ssa_wprot.sv
module ssa_wprot
  import ssa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_data,
  output logic             unlocked
);
  wp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_we) begin
      if (key_data == KEY_FIRST)                             st_d = WP_HALF;
      else if (st_q == WP_HALF && key_data == KEY_SECOND)    st_d = WP_OPEN;
      else                                                   st_d = WP_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WP_LOCKED;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == WP_OPEN);
endmodule

// File: rtl/ssa_cfg_reg.sv
module ssa_cfg_reg #(
  parameter int SS_W     = 15,
  parameter int MASK_W   = 4,
  parameter int DATA_W   = 32,
  parameter int MASK_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MASK_W-1:0] wmask,
  input  logic [SS_W-1:0]   wmatch,
  output logic [MASK_W-1:0] mask,
  output logic [SS_W-1:0]   match,
  output logic [DATA_W-1:0] rdata
);
  localparam int GAP_W = MASK_LSB - SS_W;
  localparam int TOP_W = DATA_W - MASK_LSB - MASK_W;

  logic [MASK_W-1:0] mask_q, mask_d;
  logic [SS_W-1:0]   match_q, match_d;

  always_comb begin
    mask_d  = mask_q;
    match_d = match_q;
    if (we) begin
      mask_d  = wmask;
      match_d = wmatch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      match_q <= '0;
    end else begin
      mask_q  <= mask_d;
      match_q <= match_d;
    end
  end

  assign mask  = mask_q;
  assign match = match_q;
  assign rdata = {{TOP_W{1'b0}}, mask_q, {GAP_W{1'b0}}, match_q};
endmodule

// File: rtl/ssa_match.sv
module ssa_match #(
  parameter int SS_W   = 15,
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MASK_W-1:0] mask,
  input  logic [SS_W-1:0]   match,
  input  logic [SS_W-1:0]   cnt,
  input  logic              sec_tick,
  input  logic              fields_match,
  input  logic              flag_clr,
  output logic              pulse,
  output logic              flag
);
  logic [SS_W-1:0] cmp_sel;
  logic            ss_eq, hit, rise;
  logic            hit_q, hit_d, pulse_q, pulse_d, flag_q, flag_d;

  // bit i takes part when the mask value exceeds i
  for (genvar i = 0; i < SS_W; i++) begin : g_sel
    assign cmp_sel[i] = (mask > MASK_W'(i));
  end

  always_comb begin
    ss_eq   = (((cnt ^ match) & cmp_sel) == '0);
    hit     = fields_match & ((mask == '0) ? sec_tick : ss_eq);
    rise    = hit & ~hit_q;
    hit_d   = hit;
    pulse_d = rise;
    flag_d  = rise | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign pulse = pulse_q;
  assign flag  = flag_q;
endmodule

// File: rtl/ssalarm_cmp.sv
module ssalarm_cmp
  import ssa_pkg::*;
#(
  parameter int SS_W     = 15,
  parameter int MASK_W   = 4,
  parameter int DATA_W   = 32,
  parameter int MASK_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_bkp_n,
  input  logic              rst_sys_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alm_wr_allow,
  input  logic              init_mode,
  input  logic [SS_W:0]     ss_cnt,
  input  logic              sec_tick,
  input  logic              fields_match,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              wp_unlocked,
  output logic              alarm_pulse,
  output logic              alarm_flag
);
  logic              bkp_rst_n, sys_rst_n;
  logic              cfg_we, key_we, flag_clr;
  logic [MASK_W-1:0] mask;
  logic [SS_W-1:0]   match;
  wsel_e             sel;
  logic              unused_bits;

  assign unused_bits = ^{wr_data[DATA_W-1:MASK_LSB+MASK_W],
                         wr_data[MASK_LSB-1:SS_W], ss_cnt[SS_W]};

  ssa_rst_sync #(.STAGES(2)) u_bkp_sync (
    .clk(clk), .arst_n(rst_bkp_n), .srst_n(bkp_rst_n));
  ssa_rst_sync #(.STAGES(2)) u_sys_sync (
    .clk(clk), .arst_n(rst_sys_n), .srst_n(sys_rst_n));

  always_comb begin
    sel      = wsel_e'(wr_sel);
    key_we   = wr_en && (sel == SEL_KEY);
    cfg_we   = wr_en && (sel == SEL_CFG) && wp_unlocked && (alm_wr_allow || init_mode);
    flag_clr = wr_en && (sel == SEL_FLAG) && !wr_data[0];
  end

  ssa_wprot u_wprot (
    .clk(clk), .rst_n(sys_rst_n), .key_we(key_we),
    .key_data(wr_data[KEY_W-1:0]), .unlocked(wp_unlocked));

  ssa_cfg_reg #(.SS_W(SS_W), .MASK_W(MASK_W), .DATA_W(DATA_W), .MASK_LSB(MASK_LSB)) u_cfg (
    .clk(clk), .rst_n(bkp_rst_n), .we(cfg_we),
    .wmask(wr_data[MASK_LSB+MASK_W-1:MASK_LSB]), .wmatch(wr_data[SS_W-1:0]),
    .mask(mask), .match(match), .rdata(cfg_rdata));

  ssa_match #(.SS_W(SS_W), .MASK_W(MASK_W)) u_match (
    .clk(clk), .rst_n(sys_rst_n), .mask(mask), .match(match),
    .cnt(ss_cnt[SS_W-1:0]), .sec_tick(sec_tick), .fields_match(fields_match),
    .flag_clr(flag_clr), .pulse(alarm_pulse), .flag(alarm_flag));
endmodule

// File: rtl/ssa_chk.sv
module ssa_chk (
  input logic        clk,
  input logic        rst_bkp_n,
  input logic        rst_sys_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        alm_wr_allow,
  input logic        init_mode,
  input logic        sec_tick,
  input logic        fields_match,
  input logic [31:0] cfg_rdata,
  input logic        wp_unlocked,
  input logic        alarm_pulse,
  input logic        alarm_flag
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_bkp_n)
    (cfg_rdata[31:28] == 4'd0) && (cfg_rdata[23:15] == 9'd0));

  p_unlock_key_r3: assert property (@(posedge clk) disable iff (!rst_sys_n)
    $rose(wp_unlocked) |-> $past(wr_en && wr_sel == 2'd1 && wr_data[7:0] == 8'h53));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_bkp_n)
    !(wr_en && wr_sel == 2'd0 && wp_unlocked && (alm_wr_allow || init_mode))
      |=> $stable(cfg_rdata));

  p_zero_mask_tick_r5: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (alarm_pulse && $past(cfg_rdata[27:24]) == 4'd0) |-> $past(sec_tick));

  p_needs_fields_r9: assert property (@(posedge clk) disable iff (!rst_sys_n)
    alarm_pulse |-> $past(fields_match));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_sys_n)
    alarm_pulse |=> !alarm_pulse);

  p_pulse_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_sys_n)
    alarm_pulse |-> alarm_flag);
endmodule

bind ssalarm_cmp ssa_chk u_chk (
  .clk(clk), .rst_bkp_n(rst_bkp_n), .rst_sys_n(rst_sys_n),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .alm_wr_allow(alm_wr_allow), .init_mode(init_mode),
  .sec_tick(sec_tick), .fields_match(fields_match),
  .cfg_rdata(cfg_rdata), .wp_unlocked(wp_unlocked),
  .alarm_pulse(alarm_pulse), .alarm_flag(alarm_flag));

// File: tb/ssalarm_cmp_tb_top.sv
`timescale 1ns/1ps
module ssalarm_cmp_tb_top;
  logic        clk = 1'b0;
  logic        rst_bkp_n, rst_sys_n, wr_en, alm_wr_allow, init_mode, sec_tick, fields_match;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data, cfg_rdata;
  logic [15:0] ss_cnt;
  logic        wp_unlocked, alarm_pulse, alarm_flag;

  always #2 clk = ~clk;

  ssalarm_cmp dut_i (
    .clk(clk), .rst_bkp_n(rst_bkp_n), .rst_sys_n(rst_sys_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .alm_wr_allow(alm_wr_allow), .init_mode(init_mode),
    .ss_cnt(ss_cnt), .sec_tick(sec_tick), .fields_match(fields_match),
    .cfg_rdata(cfg_rdata), .wp_unlocked(wp_unlocked),
    .alarm_pulse(alarm_pulse), .alarm_flag(alarm_flag));

  int    checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference state
  logic [3:0]  m_mask;
  logic [14:0] m_ss;
  int          m_st;
  bit          m_cd, m_pulse, m_flag;
  int          cnt_val = 0, pre = 20;
  bit          run_cnt = 0, ovf = 0;
  int          pulses = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit eq, cond, rise, clr, wcfg;
    if (!rst_bkp_n) begin m_mask = 0; m_ss = 0; end
    if (!rst_sys_n) begin m_st = 0; m_cd = 0; m_pulse = 0; m_flag = 0; return; end
    eq = 1;
    for (int i = 0; i < 15; i++) if (i < int'(m_mask) && ss_cnt[i] != m_ss[i]) eq = 0;
    cond = fields_match && ((m_mask == 0) ? sec_tick : eq);
    rise = cond && !m_cd;
    clr  = wr_en && wr_sel == 2'd2 && !wr_data[0];
    wcfg = wr_en && wr_sel == 2'd0 && m_st == 2 && (alm_wr_allow || init_mode);
    if (wr_en && wr_sel == 2'd1) begin
      if (wr_data[7:0] == 8'hCA)                   m_st = 1;
      else if (m_st == 1 && wr_data[7:0] == 8'h53) m_st = 2;
      else                                         m_st = 0;
    end
    if (rst_bkp_n && wcfg) begin m_mask = wr_data[27:24]; m_ss = wr_data[14:0]; end
    m_flag  = rise ? 1'b1 : (clr ? 1'b0 : m_flag);
    m_pulse = rise;
    m_cd    = cond;
    if (rise) pulses++;
  endtask

  task automatic step();
    if (run_cnt) begin
      if (cnt_val == 0) begin cnt_val = pre; sec_tick = 1; end
      else begin cnt_val--; sec_tick = 0; end
    end else sec_tick = 0;
    ss_cnt = {ovf, 15'(cnt_val)};
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    chk(cfg_rdata == {4'b0, m_mask, 9'b0, m_ss}, "cfg_rdata", cfg_rdata, {4'b0, m_mask, 9'b0, m_ss});
    chk(wp_unlocked == (m_st == 2), "wp_unlocked", 32'(wp_unlocked), 32'(m_st == 2));
    chk(alarm_pulse == m_pulse, "alarm_pulse", 32'(alarm_pulse), 32'(m_pulse));
    chk(alarm_flag == m_flag, "alarm_flag", 32'(alarm_flag), 32'(m_flag));
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1; wr_sel = sel; wr_data = data;
    step();
    wr_en = 0; wr_sel = 2'd3; wr_data = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      finish_run();
    end
  end

  initial begin
    rst_bkp_n = 0; rst_sys_n = 0; wr_en = 0; wr_sel = 2'd3; wr_data = 0;
    alm_wr_allow = 0; init_mode = 0; fields_match = 0; sec_tick = 0; ss_cnt = 0;
    m_mask = 0; m_ss = 0; m_st = 0; m_cd = 0; m_pulse = 0; m_flag = 0;
    @(negedge clk);
    cur_req = "R1";
    repeat (3) step();
    rst_bkp_n = 1; rst_sys_n = 1;
    repeat (4) step();

    cur_req = "R3";                       // locked: setting write ignored
    init_mode = 1; wr(2'd0, 32'h0F00_0009); step();
    wr(2'd1, 32'hCA); wr(2'd1, 32'h53); step();
    cur_req = "R4";                       // unlocked but no permission
    init_mode = 0; alm_wr_allow = 0; wr(2'd0, 32'h0F00_0009); step();
    cur_req = "R2";                       // init mode permits, reserved bits read 0
    init_mode = 1; wr(2'd0, 32'hFFFF_FFFF); step();
    cur_req = "R4";
    init_mode = 0; alm_wr_allow = 1; wr(2'd0, 32'h0F00_0009); step();
    cur_req = "R3";                       // bad key relocks
    wr(2'd1, 32'h11); wr(2'd0, 32'h0500_0001); step();
    wr(2'd1, 32'hCA); wr(2'd1, 32'hCA); wr(2'd1, 32'h53); step();

    cur_req = "R7";
    run_cnt = 1; fields_match = 1; pulses = 0;
    repeat (65) step();
    chk(pulses == 3, "pulse count", 32'(pulses), 32'd3);
    wr(2'd0, 32'h0F00_4009); pulses = 0;  // bit 14 differs: never matches
    repeat (45) step();
    chk(pulses == 0, "pulse count", 32'(pulses), 32'd0);
    cur_req = "R8";
    wr(2'd0, 32'h0F00_0009); ovf = 1;
    repeat (45) step();
    cur_req = "R9";
    fields_match = 0; repeat (45) step();
    fields_match = 1; ovf = 0;
    cur_req = "R6";
    wr(2'd0, 32'h0300_7FF5); repeat (45) step();
    wr(2'd0, 32'h0100_0000); repeat (20) step();
    wr(2'd0, 32'h0E00_4009); pulses = 0; repeat (45) step();
    chk(pulses == 2, "pulse count", 32'(pulses), 32'd2);
    cur_req = "R5";
    wr(2'd0, 32'h0000_1234); pulses = 0; repeat (45) step();
    chk(pulses == 2, "pulse count", 32'(pulses), 32'd2);
    fields_match = 0; repeat (22) step(); fields_match = 1;

    cur_req = "R10";                      // held condition: one pulse only
    run_cnt = 0; cnt_val = 6;
    wr(2'd0, 32'h0F00_0005); step();
    cnt_val = 5; pulses = 0;
    repeat (8) step();
    chk(pulses == 1, "pulse count", 32'(pulses), 32'd1);
    cur_req = "R11";
    wr(2'd2, 32'h1); step();              // writing 1 leaves the flag
    wr(2'd2, 32'h0); step();              // clear
    cnt_val = 6; step(); step();
    cnt_val = 5; wr(2'd2, 32'h0); step(); // set wins over clear
    wr(2'd2, 32'h0); step();

    cur_req = "R1";                       // system reset keeps setting
    fields_match = 0;
    rst_sys_n = 0; repeat (3) step();
    rst_sys_n = 1; repeat (4) step();
    rst_bkp_n = 0; repeat (3) step();
    rst_bkp_n = 1; repeat (4) step();
    finish_run();
  end
endmodule